// File: doc/BRIEF.md
# Linear Sensor Acquisition Controller

This block runs a linear photodiode array from the host side. After a start command it produces the two digital control lines the array needs: a frame-start strobe and a pixel clock. At the same time it tells an external ADC when to convert each pixel, and it passes the converted words downstream as an indexed stream. A frame starts with a single frame-start pulse. That pulse is captured by the first rising edge of the pixel clock. Each of the first `NPIX` rising edges places one pixel on the sensor's analog output, and one more rising edge closes the frame. After that the controller waits a programmable quiet time before it may start the next frame. That quiet time is what lets charge transfer finish inside the sensor. It also adds any extra exposure the host asks for.

Timing is counted in system clocks. The pixel clock half-period comes from a divider input, with a lower limit set by a parameter so the generated clock never runs faster than the sensor allows. A settle count delays each convert strobe after the rising edge that presents a pixel. The ADC answers with a valid-qualified data word. The output stream holds a word until the sink accepts it. If a new word arrives while the slot is still full, the new word is discarded and a flag is raised, so the loss is never silent.

Top module: `lsa_acq_ctrl`

## Requirements
- R1: After reset the frame-start line, pixel clock, convert strobe, stream valid and overflow flag are all low. While idle the frame-start line stays low.
- R2: A frame begins with the frame-start line rising while the pixel clock is low. The first pixel clock rise follows H system clocks later, with frame-start high. Frame-start falls in the same cycle as the first pixel clock fall, so it is low at the second rise.
- R3: The pixel clock high and low phases each last H = max(divider, MIN_HALF) system clocks. The divider is sampled once at frame start, and changes to it during a frame have no effect on that frame.
- R4: Each frame has exactly NPIX+1 pixel clock rises. The clock is low after the final fall.
- R5: Each of the first NPIX rises is followed by one single-cycle convert strobe, exactly settle+1 system clocks after the rise. The final rise produces no strobe.
- R6: Stream words come out in order with index 0 to NPIX-1, carrying the ADC word returned for that pixel. The last flag is high only with index NPIX-1.
- R7: The next frame-start rise comes no earlier than G+I+1 system clocks after the final pixel clock fall, where G = max(gap, 1) and I = the integration delay, both sampled at frame start. With start held high it comes exactly then.
- R8: While stream valid is high and ready is low, valid, data and index stay unchanged.
- R9: An ADC word that arrives while the stream slot is full and not being accepted sets the overflow flag, and the held word is kept. The flag clears when the next frame starts.
- R10: An ADC valid pulse with no conversion outstanding is ignored and produces no stream word.
- R11: A start request during a frame, or during the gap after it, is ignored. No extra frame-start pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Frame request, taken when idle |
| div_i | input | DIV_W | Pixel clock half-period in system clocks |
| gap_i | input | DLY_W | Charge-transfer gap after the last clock (0 acts as 1) |
| integ_i | input | DLY_W | Extra integration delay added after the gap |
| settle_i | input | SET_W | Strobe delay after a pixel-presenting rise |
| sen_si_o | output | 1 | Frame-start line to the sensor |
| sen_clk_o | output | 1 | Pixel clock to the sensor |
| adc_conv_o | output | 1 | One-cycle convert strobe to the ADC |
| adc_valid_i | input | 1 | ADC result valid |
| adc_data_i | input | SMP_W | ADC result word |
| pix_valid_o | output | 1 | Stream word valid |
| pix_ready_i | input | 1 | Stream sink ready |
| pix_data_o | output | SMP_W | Stream pixel word |
| pix_idx_o | output | IDX_W | Stream pixel index |
| pix_last_o | output | 1 | Marks the final pixel of a frame |
| busy_err_o | output | 1 | Sticky overflow flag, cleared at frame start |

## Verification
The bench builds the block with NPIX=16 and MIN_HALF=4, so frames are short. That lets it run many frames with random dividers, gaps, delays, settle counts and ADC latencies, including frames where start stays held and the exact gap can be measured. A divider of 2 is clamped up to the floor of 4, which exercises the speed limit. A sink that never accepts drives the overflow path. Because every timing count stays small, the bench can check each edge position against H, G, I and the settle count cycle by cycle.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_GAP   = 2'd2,
    ST_INTEG = 2'd3
  } seq_state_e;
endpackage

// File: rtl/lsa_halfclk.sv
// Half-period timer: toggles the pixel clock every half_i system clocks
// while run_i is high; clock parks low otherwise.
module lsa_halfclk #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              sclk_o,
  output logic              rise_o,
  output logic              fall_o
);
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              sclk_q, sclk_d;
  logic              wrap;

  assign wrap = run_i && (cnt_q == (half_i - 1'b1));

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = wrap && !sclk_q;
  assign fall_o = wrap && sclk_q;

  // R4: the clock never moves while the timer is stopped
  p_park_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !sclk_q);
endmodule

// File: rtl/lsa_seq.sv
// Frame sequencer: start acceptance, parameter capture, edge counting,
// frame-start line, and the gap/integration wait before the next frame.
module lsa_seq
  import lsa_pkg::*;
#(
  parameter int NPIX     = 128,
  parameter int MIN_HALF = 13,
  parameter int DIV_W    = 8,
  parameter int DLY_W    = 16,
  parameter int SET_W    = 6,
  localparam int EW      = $clog2(NPIX + 2),
  localparam int IW      = $clog2(NPIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DLY_W-1:0] gap_i,
  input  logic [DLY_W-1:0] integ_i,
  input  logic [SET_W-1:0] settle_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             run_o,
  output logic [DIV_W-1:0] half_o,
  output logic             si_o,
  output logic             pix_rise_o,
  output logic [IW-1:0]    pix_num_o,
  output logic [SET_W-1:0] settle_o,
  output logic             frame_start_o
);
  localparam logic [EW-1:0] EDGE_LAST  = EW'(NPIX + 1);
  localparam logic [EW-1:0] EDGE_PIX   = EW'(NPIX);
  localparam logic [EW-1:0] EDGE_FIRST = EW'(1);

  seq_state_e       st_q, st_d;
  logic             si_q, si_d;
  logic [EW-1:0]    ecnt_q, ecnt_d;
  logic [DLY_W-1:0] dcnt_q, dcnt_d;
  logic [DIV_W-1:0] half_q, half_d;
  logic [DLY_W-1:0] gap_q, gap_d;
  logic [DLY_W-1:0] integ_q, integ_d;
  logic [SET_W-1:0] settle_q, settle_d;
  logic [DIV_W-1:0] half_eff;
  logic [DLY_W-1:0] gap_eff;
  logic             accept;

  assign half_eff = (div_i < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : div_i;
  assign gap_eff  = (gap_i == '0) ? DLY_W'(1) : gap_i;
  assign accept   = (st_q == ST_IDLE) && start_i;

  always_comb begin
    st_d     = st_q;
    si_d     = si_q;
    ecnt_d   = ecnt_q;
    dcnt_d   = dcnt_q;
    half_d   = half_q;
    gap_d    = gap_q;
    integ_d  = integ_q;
    settle_d = settle_q;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d     = ST_RUN;
          si_d     = 1'b1;
          ecnt_d   = '0;
          half_d   = half_eff;
          gap_d    = gap_eff;
          integ_d  = integ_i;
          settle_d = settle_i;
        end
      end
      ST_RUN: begin
        if (rise_i) ecnt_d = ecnt_q + 1'b1;
        if (fall_i) begin
          if (ecnt_q == EDGE_FIRST) si_d = 1'b0;
          if (ecnt_q == EDGE_LAST) begin
            st_d   = ST_GAP;
            dcnt_d = gap_q - 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (dcnt_q == '0) begin
          if (integ_q == '0) begin
            st_d = ST_IDLE;
          end else begin
            st_d   = ST_INTEG;
            dcnt_d = integ_q - 1'b1;
          end
        end else begin
          dcnt_d = dcnt_q - 1'b1;
        end
      end
      ST_INTEG: begin
        if (dcnt_q == '0) st_d = ST_IDLE;
        else              dcnt_d = dcnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      si_q     <= 1'b0;
      ecnt_q   <= '0;
      dcnt_q   <= '0;
      half_q   <= DIV_W'(MIN_HALF);
      gap_q    <= DLY_W'(1);
      integ_q  <= '0;
      settle_q <= '0;
    end else begin
      st_q     <= st_d;
      si_q     <= si_d;
      ecnt_q   <= ecnt_d;
      dcnt_q   <= dcnt_d;
      half_q   <= half_d;
      gap_q    <= gap_d;
      integ_q  <= integ_d;
      settle_q <= settle_d;
    end
  end

  assign run_o         = (st_q == ST_RUN);
  assign half_o        = half_q;
  assign si_o          = si_q;
  assign pix_rise_o    = rise_i && (ecnt_q < EDGE_PIX);
  assign pix_num_o     = ecnt_q[IW-1:0];
  assign settle_o      = settle_q;
  assign frame_start_o = accept;

  // R1: idle never drives the frame-start line
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !si_q);
  // R4: the edge count never passes the terminating edge
  p_edges_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt_q <= EDGE_LAST);
  // R7: no frame-start during the charge-transfer gap
  p_gap_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP) |=> !$rose(si_q));
  // R11: a frame-start pulse only ever leaves the idle state
  p_si_from_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si_q) |-> ($past(st_q) == ST_IDLE));
endmodule

// File: rtl/lsa_pixcap.sv
// Per-pixel convert strobe after a settle delay, ADC result capture and
// a single-entry output slot with overflow reporting.
module lsa_pixcap #(
  parameter int NPIX  = 128,
  parameter int SET_W = 6,
  parameter int SMP_W = 12,
  localparam int IW   = $clog2(NPIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_rise_i,
  input  logic [IW-1:0]    pix_num_i,
  input  logic [SET_W-1:0] settle_i,
  input  logic             frame_start_i,
  input  logic             adc_valid_i,
  input  logic [SMP_W-1:0] adc_data_i,
  input  logic             ready_i,
  output logic             conv_o,
  output logic             valid_o,
  output logic [SMP_W-1:0] data_o,
  output logic [IW-1:0]    idx_o,
  output logic             last_o,
  output logic             err_o
);
  localparam logic [IW-1:0] IDX_LAST = IW'(NPIX - 1);

  logic             pend_q, pend_d;
  logic [SET_W-1:0] scnt_q, scnt_d;
  logic [IW-1:0]    pidx_q, pidx_d;
  logic             conv_q, conv_d;
  logic             wait_q, wait_d;
  logic [IW-1:0]    widx_q, widx_d;
  logic             val_q, val_d;
  logic [SMP_W-1:0] dat_q, dat_d;
  logic [IW-1:0]    oidx_q, oidx_d;
  logic             err_q, err_d;
  logic             take, slot_free;

  assign take      = wait_q && adc_valid_i;
  assign slot_free = !val_q || ready_i;

  always_comb begin
    pend_d = pend_q;
    scnt_d = scnt_q;
    pidx_d = pidx_q;
    conv_d = 1'b0;
    wait_d = wait_q;
    widx_d = widx_q;
    val_d  = val_q;
    dat_d  = dat_q;
    oidx_d = oidx_q;
    err_d  = err_q;
    if (val_q && ready_i) val_d = 1'b0;
    if (take) begin
      wait_d = 1'b0;
      if (slot_free) begin
        val_d  = 1'b1;
        dat_d  = adc_data_i;
        oidx_d = widx_q;
      end else begin
        err_d  = 1'b1;
      end
    end
    if (pix_rise_i) begin
      pend_d = 1'b1;
      scnt_d = settle_i;
      pidx_d = pix_num_i;
    end else if (pend_q) begin
      if (scnt_q == '0) begin
        pend_d = 1'b0;
        conv_d = 1'b1;
        wait_d = 1'b1;
        widx_d = pidx_q;
      end else begin
        scnt_d = scnt_q - 1'b1;
      end
    end
    if (frame_start_i) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      scnt_q <= '0;
      pidx_q <= '0;
      conv_q <= 1'b0;
      wait_q <= 1'b0;
      widx_q <= '0;
      val_q  <= 1'b0;
      dat_q  <= '0;
      oidx_q <= '0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      scnt_q <= scnt_d;
      pidx_q <= pidx_d;
      conv_q <= conv_d;
      wait_q <= wait_d;
      widx_q <= widx_d;
      val_q  <= val_d;
      dat_q  <= dat_d;
      oidx_q <= oidx_d;
      err_q  <= err_d;
    end
  end

  assign conv_o  = conv_q;
  assign valid_o = val_q;
  assign data_o  = dat_q;
  assign idx_o   = oidx_q;
  assign last_o  = val_q && (oidx_q == IDX_LAST);
  assign err_o   = err_q;

  // R5: strobe lasts a single system clock
  p_conv_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_q |=> !conv_q);
  // R8: a stalled word is held unchanged
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (val_q && !ready_i) |=> (val_q && $stable(dat_q) && $stable(oidx_q)));
  // R9: a result landing on a full, stalled slot raises the flag
  p_overflow_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && val_q && !ready_i && !frame_start_i) |=> (err_q && $stable(dat_q)));
  // R10: a stray result with nothing outstanding yields no word
  p_stray_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_q && adc_valid_i && !val_q) |=> !val_q);
endmodule

// File: rtl/lsa_acq_ctrl.sv
// Top: reset release, pixel clock timer, frame sequencer, pixel capture.
module lsa_acq_ctrl #(
  parameter int NPIX     = 128,
  parameter int MIN_HALF = 13,
  parameter int DIV_W    = 8,
  parameter int DLY_W    = 16,
  parameter int SET_W    = 6,
  parameter int SMP_W    = 12,
  localparam int IDX_W   = $clog2(NPIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DLY_W-1:0] gap_i,
  input  logic [DLY_W-1:0] integ_i,
  input  logic [SET_W-1:0] settle_i,
  output logic             sen_si_o,
  output logic             sen_clk_o,
  output logic             adc_conv_o,
  input  logic             adc_valid_i,
  input  logic [SMP_W-1:0] adc_data_i,
  output logic             pix_valid_o,
  input  logic             pix_ready_i,
  output logic [SMP_W-1:0] pix_data_o,
  output logic [IDX_W-1:0] pix_idx_o,
  output logic             pix_last_o,
  output logic             busy_err_o
);
  logic [1:0]       rs_q;
  logic             rst_s;
  logic             run, rise, fall, pix_rise, frame_start;
  logic [DIV_W-1:0] half;
  logic [IDX_W-1:0] pix_num;
  logic [SET_W-1:0] settle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  lsa_halfclk #(.HALF_W(DIV_W)) u_clk (
    .clk    (clk),
    .rst_n  (rst_s),
    .run_i  (run),
    .half_i (half),
    .sclk_o (sen_clk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  lsa_seq #(
    .NPIX(NPIX), .MIN_HALF(MIN_HALF), .DIV_W(DIV_W),
    .DLY_W(DLY_W), .SET_W(SET_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_s),
    .start_i       (start_i),
    .div_i         (div_i),
    .gap_i         (gap_i),
    .integ_i       (integ_i),
    .settle_i      (settle_i),
    .rise_i        (rise),
    .fall_i        (fall),
    .run_o         (run),
    .half_o        (half),
    .si_o          (sen_si_o),
    .pix_rise_o    (pix_rise),
    .pix_num_o     (pix_num),
    .settle_o      (settle),
    .frame_start_o (frame_start)
  );

  lsa_pixcap #(.NPIX(NPIX), .SET_W(SET_W), .SMP_W(SMP_W)) u_cap (
    .clk           (clk),
    .rst_n         (rst_s),
    .pix_rise_i    (pix_rise),
    .pix_num_i     (pix_num),
    .settle_i      (settle),
    .frame_start_i (frame_start),
    .adc_valid_i   (adc_valid_i),
    .adc_data_i    (adc_data_i),
    .ready_i       (pix_ready_i),
    .conv_o        (adc_conv_o),
    .valid_o       (pix_valid_o),
    .data_o        (pix_data_o),
    .idx_o         (pix_idx_o),
    .last_o        (pix_last_o),
    .err_o         (busy_err_o)
  );

  // R2: frame-start rises only while the pixel clock is low
  p_si_rise_clk_low_r2: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(sen_si_o) |-> !sen_clk_o);
  // R2: frame-start drops together with a pixel clock fall
  p_si_fall_with_clk_r2: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(sen_si_o) |-> $fell(sen_clk_o));
endmodule

// File: tb/sim_lsa_acq_ctrl.sv
`timescale 1ns/1ps
module sim_lsa_acq_ctrl;
  localparam int NPIX = 16, MINH = 4, DIVW = 8, DLYW = 10, SETW = 4, SMPW = 10;
  localparam int IW = $clog2(NPIX);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n, start, adc_valid, pix_ready;
  logic [DIVW-1:0] div;
  logic [DLYW-1:0] gap, integ;
  logic [SETW-1:0] settle;
  logic [SMPW-1:0] adc_data;
  logic            si, sclk, conv, pix_valid, pix_last, busy_err;
  logic [SMPW-1:0] pix_data;
  logic [IW-1:0]   pix_idx;

  lsa_acq_ctrl #(.NPIX(NPIX), .MIN_HALF(MINH), .DIV_W(DIVW), .DLY_W(DLYW),
                 .SET_W(SETW), .SMP_W(SMPW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .div_i(div), .gap_i(gap),
    .integ_i(integ), .settle_i(settle), .sen_si_o(si), .sen_clk_o(sclk),
    .adc_conv_o(conv), .adc_valid_i(adc_valid), .adc_data_i(adc_data),
    .pix_valid_o(pix_valid), .pix_ready_i(pix_ready), .pix_data_o(pix_data),
    .pix_idx_o(pix_idx), .pix_last_o(pix_last), .busy_err_o(busy_err));

  int nchk = 0, nerr = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int word(input int f, input int k);
    return (f * 37 + k * 11 + 5) % (1 << SMPW);
  endfunction

  // expected configuration of the next frame
  int cfg_h, cfg_s, cfg_gi, adc_lat, sink_mode;
  bit mon_on = 0, chk_stream = 1, stray = 0;
  // monitor state
  int cyc = 0, fr_h, fr_s, prev_gi, rises, last_rise, last_fall, si_cyc;
  int convk, exp_idx, frame_no = 0, stall_n = 0, adc_cnt = 0, adc_k = 0, adc_kk;
  bit in_frame = 0, frame_done = 0, start_kept = 0, psi = 0, pclk = 0;
  bit pval = 0, prdy = 0, rdy;
  logic [SMPW-1:0] pdat;
  logic [IW-1:0]   pidx;

  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if (sink_mode == 0)      rdy = 1'b1;
      else if (sink_mode == 2) rdy = 1'b0;
      else                     rdy = (($urandom % 4) != 0) || (stall_n >= 2);
      pix_ready = rdy;
      if (pix_valid && !rdy) stall_n++; else stall_n = 0;
      if (pval && !prdy)
        chk(pix_valid && pix_data == pdat && pix_idx == pidx, "R8 held word", int'(pix_data), int'(pdat));
      pval = pix_valid; prdy = rdy; pdat = pix_data; pidx = pix_idx;
      if (chk_stream && pix_valid && rdy) begin
        chk(int'(pix_idx) == exp_idx, "R6 index", int'(pix_idx), exp_idx);
        chk(int'(pix_data) == word(frame_no, exp_idx), "R6 data", int'(pix_data), word(frame_no, exp_idx));
        chk(pix_last == (exp_idx == NPIX - 1), "R6 last", int'(pix_last), int'(exp_idx == NPIX - 1));
        exp_idx++;
      end
      if (!start) start_kept = 0;
      if (si && !psi) begin
        chk(!in_frame, "R11 extra frame-start", 1, 0);
        if (frame_no > 0) begin
          if (start_kept) chk(cyc - last_fall == prev_gi + 1, "R7 exact gap", cyc - last_fall, prev_gi + 1);
          else            chk(cyc - last_fall >= prev_gi + 1, "R7 min gap", cyc - last_fall, prev_gi + 1);
        end
        chk(!sclk, "R2 clk low at start", int'(sclk), 0);
        frame_no++; in_frame = 1; rises = 0; convk = 0; exp_idx = 0; adc_k = 0;
        si_cyc = cyc; fr_h = cfg_h; fr_s = cfg_s; prev_gi = cfg_gi;
      end
      if (!si && psi) chk(!sclk && pclk, "R2 si falls with clk", int'(sclk), 0);
      if (sclk && !pclk) begin
        rises++;
        if (rises == 1) begin
          chk(cyc - si_cyc == fr_h, "R2 first rise delay", cyc - si_cyc, fr_h);
          chk(si, "R2 si high at first rise", int'(si), 1);
        end else begin
          chk(cyc - last_rise == 2 * fr_h, "R3 period", cyc - last_rise, 2 * fr_h);
        end
        if (rises == 2) chk(!si, "R2 si low at second rise", int'(si), 0);
        chk(rises <= NPIX + 1, "R4 rise count", rises, NPIX + 1);
        last_rise = cyc;
      end
      if (!sclk && pclk) begin
        chk(cyc - last_rise == fr_h, "R3 high phase", cyc - last_rise, fr_h);
        last_fall = cyc;
        if (rises == NPIX + 1) begin
          in_frame = 0; frame_done = 1; start_kept = 1;
        end
      end
      if (conv) begin
        chk(cyc - last_rise == fr_s + 1 && rises <= NPIX, "R5 strobe position", cyc - last_rise, fr_s + 1);
        convk++;
      end
      // ADC model
      adc_valid = 1'b0;
      if (stray) begin adc_valid = 1'b1; adc_data = '1; stray = 0; end
      if (adc_cnt > 0) begin
        adc_cnt--;
        if (adc_cnt == 0) begin adc_valid = 1'b1; adc_data = SMPW'(word(frame_no, adc_kk)); end
      end
      if (conv) begin adc_kk = adc_k; adc_k++; adc_cnt = adc_lat; end
      psi = si; pclk = sclk;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      summary();
    end
  end

  task automatic run_frame(input int d, input int g, input int i, input int s,
                           input int lat, input int mode, input bit hold, input bit poke);
    @(negedge clk);
    cfg_h  = (d < MINH) ? MINH : d;
    cfg_gi = ((g == 0) ? 1 : g) + i;
    cfg_s  = s;
    div = DIVW'(d); gap = DLYW'(g); integ = DLYW'(i); settle = SETW'(s);
    adc_lat = lat; sink_mode = mode; start = 1'b1;
    do @(negedge clk); while (!in_frame);
    if (!hold) start = 1'b0;
    @(negedge clk);
    chk(!busy_err, "R9 flag cleared at frame start", int'(busy_err), 0);
    div = DIVW'(cfg_h + 3);  // R3: mid-frame divider change must be ignored
    if (poke) begin
      start = 1'b1; @(negedge clk); start = 1'b0;  // R11
    end
    while (!frame_done) @(negedge clk);
    frame_done = 0;
    chk(rises == NPIX + 1, "R4 rises per frame", rises, NPIX + 1);
    chk(!sclk, "R4 clk low after frame", int'(sclk), 0);
    chk(convk == NPIX, "R5 strobe count", convk, NPIX);
    if (chk_stream) chk(exp_idx == NPIX, "R6 word count", exp_idx, NPIX);
  endtask

  initial begin
    int rv;
    rv = $urandom(32'd1234);
    rst_n = 1'b0; start = 1'b0; div = DIVW'(MINH); gap = '0; integ = '0; settle = '0;
    adc_valid = 1'b0; adc_data = '0; pix_ready = 1'b0;
    cfg_h = MINH; cfg_s = 0; cfg_gi = 1; adc_lat = 1; sink_mode = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!si, "R1 si after reset", int'(si), 0);
    chk(!sclk, "R1 clk after reset", int'(sclk), 0);
    chk(!conv, "R1 strobe after reset", int'(conv), 0);
    chk(!pix_valid, "R1 valid after reset", int'(pix_valid), 0);
    chk(!busy_err, "R1 flag after reset", int'(busy_err), 0);
    mon_on = 1;
    // R10: stray ADC valid while idle
    @(negedge clk); stray = 1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!pix_valid, "R10 stray result ignored", int'(pix_valid), 0);
    end
    // directed corners
    run_frame(2, 0, 0, 0, 1, 0, 0, 1);   // clamp to floor, zero gap, start poke
    run_frame(5, 7, 3, 2, 2, 1, 1, 0);   // start held for exact gap
    run_frame(6, 9, 4, 4, 3, 1, 0, 1);
    // random frames
    for (int n = 0; n < 8; n++) begin
      int h, hd, g;
      bit hold;
      h = MINH + ($urandom % 6);
      hold = ($urandom % 2) == 1;
      g = hold ? 5 + ($urandom % 15) : ($urandom % 20);
      hd = h;
      run_frame(hd, g, $urandom % 15, $urandom % (2 * h - 2), 1 + ($urandom % 3), 1, hold, !hold);
    end
    // R9: sink never ready
    chk_stream = 0;
    run_frame(5, 3, 0, 1, 2, 2, 0, 0);
    chk(busy_err, "R9 overflow flag", int'(busy_err), 1);
    chk(pix_valid, "R9 word kept", int'(pix_valid), 1);
    chk(int'(pix_idx) == 0, "R9 kept index", int'(pix_idx), 0);
    chk(int'(pix_data) == word(frame_no, 0), "R9 kept data", int'(pix_data), word(frame_no, 0));
    sink_mode = 0;
    repeat (3) @(negedge clk);
    chk(!pix_valid, "R9 only one word held", int'(pix_valid), 0);
    chk_stream = 1;
    run_frame(7, 4, 2, 3, 1, 1, 0, 0);
    repeat (40) @(negedge clk);
    summary();
  end
endmodule